// File: doc/BRIEF.md
# Counter Enable Set/Clear Register

This block holds the on/off state of a performance-monitor cycle counter and of up to 31 event counters in one 32-bit vector. Software reaches the vector through two write aliases that share storage: the set alias turns on every counter whose data bit is 1, and the clear alias turns off every counter whose data bit is 1. A zero data bit leaves its counter alone in both aliases. A read gives the same vector no matter which alias is selected. The per-counter enable lines go straight to the counters.

Not every bit can be seen or changed by every requester. Event counters at or above the currently accessible count read as zero and ignore writes. At the user privilege level, when the design has the extended user-access feature and the user-enable control bit is set, each counter is further gated. A counter whose per-counter user-access bit is clear is hidden. A counter whose class read-only bit is set can be read but not written. Event counters beyond the implemented count do not exist in storage.

Top module: `cnt_enable_reg`

## Requirements
- R1: Bit 31 of the vector is the cycle counter enable and bit m (m < 31) is event counter m. `cntEnable[k]` is the stored state of bit k.
- R2: A write with `aliasSel`=0 (set alias) sets every writable bit whose `wrData` bit is 1 and leaves bits with `wrData`=0 unchanged.
- R3: A write with `aliasSel`=1 (clear alias) clears every writable bit whose `wrData` bit is 1 and leaves bits with `wrData`=0 unchanged.
- R4: `rdData` shows the stored vector with hidden bits forced to 0, and it does not depend on `aliasSel`.
- R5: After reset every enable bit is 0.
- R6: Event bit m with m >= `accessibleCnt` reads as 0 and ignores writes. Its stored value is kept and is visible on `cntEnable`.
- R7: Event bits at index NUM_EVT and above (bit 31 excluded) are always 0 on `cntEnable` and `rdData`.
- R8: When `privLevel`=0 (user level), the parameter EXT_USER=1 and `usrEnable`=1, a bit whose `usrAccess` bit is 0 reads as 0 and ignores writes.
- R9: Under the same user gate, the cycle bit is read-only when `usrCycRead`=1, and event bits are read-only when `usrEvtRead`=1.
- R10: At `privLevel` 1 to 3, or when `usrEnable`=0, the user-access inputs have no effect.
- R11: A write takes effect at the next rising clock edge. Without `wrEn` the vector holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| aliasSel | input | 1 | 0 = set alias, 1 = clear alias |
| wrData | input | 32 | Write data, one bit per counter |
| privLevel | input | 2 | Requester privilege, 0 = user |
| usrEnable | input | 1 | User-access enable control |
| usrCycRead | input | 1 | User read-only control for the cycle counter |
| usrEvtRead | input | 1 | User read-only control for event counters |
| usrAccess | input | 32 | Per-counter user-access bits |
| accessibleCnt | input | $clog2(NUM_EVT+1) | Number of event counters currently accessible |
| rdData | output | 32 | Masked read-back vector |
| cntEnable | output | 32 | Per-counter enable lines |

## Verification
The bench first drives all-ones masks through each alias at a privileged level, which tells apart correct per-bit set and clear behaviour from whole-word overwrites. It then lowers the accessible count and writes the hidden bits. The read must show zeros while the enable lines keep their old state, which separates hiding a bit from clearing it. Next, user-level patterns mix the access mask with the read-only controls to separate the hide rule from the read-only rule, and the same patterns are repeated with the user gate off. A long pseudo-random run varies every input each cycle against the behavioural model.

// File: rtl/cnt_enable_pkg.sv
package cnt_enable_pkg;
  localparam int REG_W   = 32;
  localparam int CYC_BIT = 31;
  localparam logic [1:0] PRIV_USER = 2'd0;

  typedef struct packed {
    logic [REG_W-1:0] setBits;
    logic [REG_W-1:0] clrBits;
    logic [REG_W-1:0] visBits;
  } ctrl_strobe_t;
endpackage

// File: rtl/cnt_enable_ctrl.sv
module cnt_enable_ctrl
  import cnt_enable_pkg::*;
#(
  parameter int NUM_EVT  = 31,
  parameter bit EXT_USER = 1'b1,
  localparam int CNT_W   = $clog2(NUM_EVT + 1)
) (
  input  logic             wrEn,
  input  logic             aliasSel,
  input  logic [REG_W-1:0] wrData,
  input  logic [1:0]       privLevel,
  input  logic             usrEnable,
  input  logic             usrCycRead,
  input  logic             usrEvtRead,
  input  logic [REG_W-1:0] usrAccess,
  input  logic [CNT_W-1:0] accessibleCnt,
  output ctrl_strobe_t     strobe
);
  logic             userGate;
  logic [REG_W-1:0] visMask;
  logic [REG_W-1:0] wrMask;
  logic [REG_W-1:0] wrHit;

  assign userGate = EXT_USER && (privLevel == PRIV_USER) && usrEnable;

  for (genvar g = 0; g < REG_W; g++) begin : g_bit
    if (g == CYC_BIT) begin : g_cyc
      logic shown;
      assign shown      = !(userGate && !usrAccess[g]);
      assign visMask[g] = shown;
      assign wrMask[g]  = shown && !(userGate && usrCycRead);
    end else if (g < NUM_EVT) begin : g_evt
      logic inRange;
      logic shown;
      assign inRange    = CNT_W'(g) < accessibleCnt;
      assign shown      = inRange && !(userGate && !usrAccess[g]);
      assign visMask[g] = shown;
      assign wrMask[g]  = shown && !(userGate && usrEvtRead);
    end else begin : g_none
      assign visMask[g] = 1'b0;
      assign wrMask[g]  = 1'b0;
    end
  end

  assign wrHit          = wrEn ? (wrData & wrMask) : '0;
  assign strobe.setBits = aliasSel ? '0 : wrHit;
  assign strobe.clrBits = aliasSel ? wrHit : '0;
  assign strobe.visBits = visMask;
endmodule

// File: rtl/cnt_enable_dp.sv
module cnt_enable_dp
  import cnt_enable_pkg::*;
#(
  parameter int NUM_EVT = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_strobe_t     strobe,
  output logic [REG_W-1:0] rdData,
  output logic [REG_W-1:0] cntEnable
);
  logic [REG_W-1:0] enQ;

  for (genvar g = 0; g < REG_W; g++) begin : g_store
    if (g == CYC_BIT || g < NUM_EVT) begin : g_real
      always_ff @(posedge clk) begin
        if (!rst_n)                 enQ[g] <= 1'b0;
        else if (strobe.setBits[g]) enQ[g] <= 1'b1;
        else if (strobe.clrBits[g]) enQ[g] <= 1'b0;
      end
    end else begin : g_tie
      assign enQ[g] = 1'b0;
    end
  end

  assign cntEnable = enQ;
  assign rdData    = enQ & strobe.visBits;
endmodule

// File: rtl/cnt_enable_reg.sv
module cnt_enable_reg
  import cnt_enable_pkg::*;
#(
  parameter int NUM_EVT  = 31,
  parameter bit EXT_USER = 1'b1,
  localparam int CNT_W   = $clog2(NUM_EVT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic             aliasSel,
  input  logic [31:0]      wrData,
  input  logic [1:0]       privLevel,
  input  logic             usrEnable,
  input  logic             usrCycRead,
  input  logic             usrEvtRead,
  input  logic [31:0]      usrAccess,
  input  logic [CNT_W-1:0] accessibleCnt,
  output logic [31:0]      rdData,
  output logic [31:0]      cntEnable
);
  ctrl_strobe_t strobe;

  cnt_enable_ctrl #(.NUM_EVT(NUM_EVT), .EXT_USER(EXT_USER)) u_ctrl (
    .wrEn(wrEn), .aliasSel(aliasSel), .wrData(wrData), .privLevel(privLevel),
    .usrEnable(usrEnable), .usrCycRead(usrCycRead), .usrEvtRead(usrEvtRead),
    .usrAccess(usrAccess), .accessibleCnt(accessibleCnt), .strobe(strobe)
  );

  cnt_enable_dp #(.NUM_EVT(NUM_EVT)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .rdData(rdData), .cntEnable(cntEnable)
  );
endmodule

// File: rtl/cnt_enable_chk.sv
module cnt_enable_chk #(
  parameter int NUM_EVT  = 31,
  parameter bit EXT_USER = 1'b1,
  localparam int CNT_W   = $clog2(NUM_EVT + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wrEn,
  input logic             aliasSel,
  input logic [31:0]      wrData,
  input logic [1:0]       privLevel,
  input logic             usrEnable,
  input logic             usrCycRead,
  input logic             usrEvtRead,
  input logic [31:0]      usrAccess,
  input logic [CNT_W-1:0] accessibleCnt,
  input logic [31:0]      rdData,
  input logic [31:0]      cntEnable
);
  logic [31:0] okMask;
  logic [31:0] absentMask;

  always_comb begin
    okMask     = '0;
    absentMask = '0;
    for (int i = 0; i < 32; i++) begin
      logic exists, gated, ro;
      exists = (i == 31) || (i < NUM_EVT);
      gated  = EXT_USER && privLevel == 2'd0 && usrEnable;
      ro     = (i == 31) ? usrCycRead : usrEvtRead;
      absentMask[i] = !exists;
      okMask[i] = exists && ((i == 31) || (i < int'(accessibleCnt)))
                  && !(gated && (!usrAccess[i] || ro));
    end
  end

  // R2
  set_turns_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && !aliasSel) |=> ((cntEnable & $past(wrData & okMask)) == $past(wrData & okMask)));
  // R3
  clr_turns_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && aliasSel) |=> ((cntEnable & $past(wrData & okMask)) == 32'd0));
  // R6
  locked_bits_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |=> ((cntEnable & ~$past(okMask)) == ($past(cntEnable) & ~$past(okMask))));
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrEn |=> $stable(cntEnable));
  // R7
  absent_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cntEnable & absentMask) == 32'd0);
  // R4
  read_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdData & ~cntEnable) == 32'd0);
endmodule

bind cnt_enable_reg cnt_enable_chk #(.NUM_EVT(NUM_EVT), .EXT_USER(EXT_USER)) u_chk (
  .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .aliasSel(aliasSel), .wrData(wrData),
  .privLevel(privLevel), .usrEnable(usrEnable), .usrCycRead(usrCycRead),
  .usrEvtRead(usrEvtRead), .usrAccess(usrAccess), .accessibleCnt(accessibleCnt),
  .rdData(rdData), .cntEnable(cntEnable)
);

// File: tb/cnt_enable_reg_tb.sv
module cnt_enable_reg_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NEVT = 6;
  localparam int CW = $clog2(NEVT + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrEn = 1'b0;
  logic aliasSel = 1'b0;
  logic [31:0] wrData = '0;
  logic [1:0] privLevel = 2'd1;
  logic usrEnable = 1'b0;
  logic usrCycRead = 1'b0;
  logic usrEvtRead = 1'b0;
  logic [31:0] usrAccess = '0;
  logic [CW-1:0] accessibleCnt = CW'(NEVT);
  logic [31:0] rdData, cntEnable;

  int checks = 0;
  int failures = 0;
  logic [31:0] model = '0;
  logic [31:0] saved;
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  cnt_enable_reg #(.NUM_EVT(NEVT), .EXT_USER(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .aliasSel(aliasSel), .wrData(wrData),
    .privLevel(privLevel), .usrEnable(usrEnable), .usrCycRead(usrCycRead),
    .usrEvtRead(usrEvtRead), .usrAccess(usrAccess), .accessibleCnt(accessibleCnt),
    .rdData(rdData), .cntEnable(cntEnable)
  );

  function automatic bit exists(int i);
    return i == 31 || i < NEVT;
  endfunction
  function automatic bit gate();
    return privLevel == 2'd0 && usrEnable;
  endfunction
  function automatic logic [31:0] visMask();
    logic [31:0] m = '0;
    for (int i = 0; i < 32; i++)
      m[i] = exists(i) && (i == 31 || i < int'(accessibleCnt)) && !(gate() && !usrAccess[i]);
    return m;
  endfunction
  function automatic logic [31:0] wrMask();
    logic [31:0] m = visMask();
    if (gate() && usrCycRead) m[31] = 1'b0;
    if (gate() && usrEvtRead) m[30:0] = '0;
    return m;
  endfunction

  task automatic compare(string tag);
    logic [31:0] expRd = model & visMask();
    checks++;
    if (rdData !== expRd) begin
      failures++;
      $display("FAIL %s rdData actual=%h expected=%h", tag, rdData, expRd);
    end
    checks++;
    if (cntEnable !== model) begin
      failures++;
      $display("FAIL %s cntEnable actual=%h expected=%h", tag, cntEnable, model);
    end
  endtask

  // one clock: model advances with the DUT, comparison at the falling edge
  task automatic step(string tag);
    logic [31:0] nxt = model;
    if (!rst_n) nxt = '0;
    else if (wrEn && !aliasSel) nxt = model | (wrData & wrMask());
    else if (wrEn && aliasSel) nxt = model & ~(wrData & wrMask());
    @(posedge clk);
    model = nxt;
    @(negedge clk);
    compare(tag);
  endtask

  task automatic write(bit clr, logic [31:0] d, string tag);
    wrEn = 1'b1; aliasSel = clr; wrData = d;
    step(tag);
    wrEn = 1'b0; wrData = '0;
    step(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    model = 32'hDEAD_BEEF;
    step("R5"); step("R5");
    rst_n = 1'b1;
    step("R5");
    // R2 R7 R1: all ones at privileged level, only bit31 and bits 0..5 exist
    write(1'b0, 32'hFFFF_FFFF, "R2");
    // R3
    write(1'b1, 32'h8000_0005, "R3");
    // R4: alias select alone changes nothing
    aliasSel = 1'b1; step("R4"); aliasSel = 1'b0; step("R4");
    // R6: hide bits 3..5, try to clear them
    accessibleCnt = CW'(3);
    step("R6");
    write(1'b1, 32'h0000_003F, "R6");
    accessibleCnt = CW'(NEVT);
    step("R6");
    // R8: user gate on, only bits 31,0,1 accessible
    write(1'b1, 32'hFFFF_FFFF, "R8");
    privLevel = 2'd0; usrEnable = 1'b1; usrAccess = 32'h8000_0003;
    write(1'b0, 32'hFFFF_FFFF, "R8");
    // R9: event read-only, cycle writable
    usrEvtRead = 1'b1;
    write(1'b1, 32'hFFFF_FFFF, "R9");
    usrCycRead = 1'b1; usrEvtRead = 1'b0;
    write(1'b0, 32'h8000_0000, "R9");
    write(1'b1, 32'h0000_0003, "R9");
    // R10: user gate off, controls ignored
    usrEnable = 1'b0; usrAccess = '0;
    write(1'b0, 32'h8000_0024, "R10");
    privLevel = 2'd2; usrEnable = 1'b1;
    write(1'b1, 32'h0000_0004, "R10");
    // R2 R3: set then clear same mask restores the vector
    saved = model;
    write(1'b0, 32'h0000_0012, "R2");
    write(1'b1, 32'h0000_0012, "R3");
    checks++;
    if (cntEnable !== (saved & ~32'h12) && (saved & 32'h12) == 0) begin
      failures++;
      $display("FAIL R3 restore actual=%h expected=%h", cntEnable, saved);
    end
    // R11: pseudo-random traffic, every cycle compared
    for (int k = 0; k < 400; k++) begin
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      wrEn = seed[0]; aliasSel = seed[1]; privLevel = seed[3:2];
      usrEnable = seed[4]; usrCycRead = seed[5]; usrEvtRead = seed[6];
      accessibleCnt = CW'(seed[10:8] % 7);
      wrData = {seed[31:16], seed[15:0] ^ seed[31:16]};
      usrAccess = {seed[7:0], seed[31:8]};
      step("R11");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule